// File: doc/BRIEF.md
# Bus and Pin Wake-Up Detector

This block watches for wake-up events while a node sits in one of its low-power states. It takes two inputs. One is a digitized bus level, where 1 means dominant and 0 means recessive. The other is a local wake input. When a valid event is seen on either one, the block emits a wake request for the mode controller that consumes it. It also reports whether the request came from the local input, so that a source flag can be kept downstream.

The remote path accepts only a dominant, recessive, dominant sequence. The first and second dominant phases must each last at least `DOM_MIN` samples, and the recessive phase must last at least `REC_MIN` samples. The whole sequence must finish within `PAT_TIMEOUT` samples, counted from the first dominant sample. A phase that ends too early drops the tracker back to idle.

The local path accepts a level change in either direction, but only once the new level has been sampled `PIN_FILT` times in a row. Both paths run only while `monitor_en` is high. The mode logic drives `monitor_en` high in its standby, go-to-sleep and sleep states. All times are cycles of one free-running clock.

Top module: `bus_pin_wake_detector`

## Requirements
- R1: A bus sequence of at least `DOM_MIN` dominant (`bus_dom`=1) samples, then at least `REC_MIN` recessive samples, then `DOM_MIN` dominant samples gives exactly one `wake_pulse`. The pulse is high in the cycle after the completing sample, with `wake_local`=0.
- R2: A first dominant phase shorter than `DOM_MIN` samples returns the tracker to idle, and the sequence gives no wake.
- R3: A recessive phase shorter than `REC_MIN` samples returns the tracker to idle, and the sequence gives no wake.
- R4: A second dominant phase shorter than `DOM_MIN` samples gives no wake.
- R5: A sequence whose completing sample is the `PAT_TIMEOUT`-th sample since its first dominant sample still wakes. One that would complete later is discarded with no wake.
- R6: A low-to-high change of `wake_pin` sampled `PIN_FILT` times in a row gives one `wake_pulse` with `wake_local`=1.
- R7: A high-to-low change of `wake_pin` sampled `PIN_FILT` times in a row gives one `wake_pulse` with `wake_local`=1.
- R8: A `wake_pin` change that reverts before `PIN_FILT` samples gives no wake.
- R9: While `monitor_en`=0 no wake is issued. Changes seen while disabled give no wake once `monitor_en` returns to 1. After that, detection works again.
- R10: During and after reset both outputs are 0. The `wake_pin` level present at reset is taken as the reference, so it never produces a wake.
- R11: `wake_pulse` lasts one cycle per event, and `wake_local` is high only together with `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| monitor_en | input | 1 | High while the node is in a low-power state |
| bus_dom | input | 1 | Digitized bus level: 1 dominant, 0 recessive |
| wake_pin | input | 1 | Local wake input |
| wake_pulse | output | 1 | One-cycle wake request |
| wake_local | output | 1 | Wake came from the local input (valid with `wake_pulse`) |

## Verification
The bench builds the block with `DOM_MIN`=4, `REC_MIN`=3, `PAT_TIMEOUT`=20 and `PIN_FILT`=5. These small values let every phase be driven one sample short of its minimum in a few cycles. They also let the shortest valid sequence (11 samples) be stretched to end exactly on the 20-sample deadline and one sample past it. A filter of 5 keeps a 4-sample glitch and a 5-sample stable level only one cycle apart, so the filter edge is tested precisely.

// File: rtl/wkdet_pkg.sv
package wkdet_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_DOM1 = 2'd1,
        PS_REC  = 2'd2,
        PS_DOM2 = 2'd3
    } pat_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wkdet_bus_pattern.sv
module wkdet_bus_pattern
    import wkdet_pkg::*;
#(
    parameter int DOM_MIN     = 4,
    parameter int REC_MIN     = 3,
    parameter int PAT_TIMEOUT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bus_dom,
    output logic remote_hit
);
    localparam int PH_MAX = max_of(DOM_MIN, REC_MIN);
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam int TW     = $clog2(PAT_TIMEOUT + 2);
    localparam logic [PW-1:0] PH_MAX_C  = PW'(PH_MAX);
    localparam logic [PW-1:0] DOM_MIN_C = PW'(DOM_MIN);
    localparam logic [PW-1:0] REC_MIN_C = PW'(REC_MIN);
    localparam logic [TW-1:0] TO_C      = TW'(PAT_TIMEOUT);

    typedef struct packed {
        pat_state_t        st;
        logic [PW-1:0]     ph;
        logic [TW-1:0]     tot;
    } trk_t;

    localparam trk_t TRK_IDLE = '{st: PS_IDLE, ph: '0, tot: '0};

    trk_t          cur, nxt;
    logic          hit_n;
    logic [PW-1:0] ph_inc;
    logic [TW-1:0] tot_inc;
    logic          late;

    always_comb begin
        ph_inc  = (cur.ph == PH_MAX_C) ? cur.ph : cur.ph + 1'b1;
        tot_inc = cur.tot + 1'b1;
        late    = (tot_inc > TO_C);
        nxt     = cur;
        hit_n   = 1'b0;
        if (cur.st != PS_IDLE) nxt.tot = tot_inc;
        if (!enable) begin
            nxt = TRK_IDLE;
        end else begin
            case (cur.st)
                PS_IDLE: begin
                    if (bus_dom) nxt = '{st: PS_DOM1, ph: PW'(1), tot: TW'(1)};
                end
                PS_DOM1: begin
                    if (bus_dom)                nxt.ph = ph_inc;
                    else if (cur.ph >= DOM_MIN_C) begin
                        nxt.st = PS_REC;
                        nxt.ph = PW'(1);
                    end else                    nxt = TRK_IDLE;
                end
                PS_REC: begin
                    if (!bus_dom)               nxt.ph = ph_inc;
                    else if (cur.ph >= REC_MIN_C) begin
                        if (DOM_MIN <= 1) begin
                            hit_n = 1'b1;
                            nxt   = TRK_IDLE;
                        end else begin
                            nxt.st = PS_DOM2;
                            nxt.ph = PW'(1);
                        end
                    end else                    nxt = TRK_IDLE;
                end
                PS_DOM2: begin
                    if (!bus_dom)               nxt = TRK_IDLE;
                    else if (ph_inc >= DOM_MIN_C) begin
                        hit_n = 1'b1;
                        nxt   = TRK_IDLE;
                    end else                    nxt.ph = ph_inc;
                end
                default: nxt = TRK_IDLE;
            endcase
            if (cur.st != PS_IDLE && late) begin
                nxt   = TRK_IDLE;
                hit_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= TRK_IDLE;
            remote_hit <= 1'b0;
        end else begin
            cur        <= nxt;
            remote_hit <= hit_n;
        end
    end

    // R5: an active pattern never outlives its deadline
    a_r5_within_deadline: assert property (@(posedge clk) disable iff (rst)
        (cur.st != PS_IDLE) |-> (cur.tot <= TO_C));

    // R1: a remote wake always follows a dominant sample
    a_r1_ends_dominant: assert property (@(posedge clk) disable iff (rst)
        remote_hit |-> $past(bus_dom));

    // R11: remote wake is a single-cycle pulse
    a_r11_remote_single: assert property (@(posedge clk) disable iff (rst)
        remote_hit |=> !remote_hit);

    // R9: nothing is reported after a disabled cycle
    a_r9_remote_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !remote_hit);
endmodule

// File: rtl/wkdet_pin_filter.sv
module wkdet_pin_filter #(
    parameter int PIN_FILT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic wake_pin,
    output logic local_hit
);
    localparam int CW = $clog2(PIN_FILT + 1);
    localparam logic [CW-1:0] FILT_C = CW'(PIN_FILT);

    logic          ref_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= wake_pin;
            cnt_q     <= '0;
            local_hit <= 1'b0;
        end else begin
            local_hit <= 1'b0;
            if (!enable) begin
                ref_q <= wake_pin;
                cnt_q <= '0;
            end else if (wake_pin == ref_q) begin
                cnt_q <= '0;
            end else if (cnt_inc >= FILT_C) begin
                ref_q     <= wake_pin;
                cnt_q     <= '0;
                local_hit <= 1'b1;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // R6/R7: a local wake moves the reference to the level just sampled
    a_r6_ref_follows: assert property (@(posedge clk) disable iff (rst)
        local_hit |-> (ref_q == $past(wake_pin)) && (ref_q != $past(ref_q)));

    // R9: no local wake right after a disabled cycle
    a_r9_local_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !local_hit);

    generate
        if (PIN_FILT > 1) begin : g_single
            // R11: local wake is a single-cycle pulse
            a_r11_local_single: assert property (@(posedge clk) disable iff (rst)
                local_hit |=> !local_hit);
        end
    endgenerate
endmodule

// File: rtl/bus_pin_wake_detector.sv
module bus_pin_wake_detector #(
    parameter int DOM_MIN     = 4,
    parameter int REC_MIN     = 3,
    parameter int PAT_TIMEOUT = 20,
    parameter int PIN_FILT    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic monitor_en,
    input  logic bus_dom,
    input  logic wake_pin,
    output logic wake_pulse,
    output logic wake_local
);
    logic remote_hit;
    logic local_hit;

    wkdet_bus_pattern #(
        .DOM_MIN     (DOM_MIN),
        .REC_MIN     (REC_MIN),
        .PAT_TIMEOUT (PAT_TIMEOUT)
    ) u_bus (
        .clk        (clk),
        .rst        (rst),
        .enable     (monitor_en),
        .bus_dom    (bus_dom),
        .remote_hit (remote_hit)
    );

    wkdet_pin_filter #(
        .PIN_FILT (PIN_FILT)
    ) u_pin (
        .clk       (clk),
        .rst       (rst),
        .enable    (monitor_en),
        .wake_pin  (wake_pin),
        .local_hit (local_hit)
    );

    assign wake_pulse = remote_hit | local_hit;
    assign wake_local = local_hit;

    // R9: outputs stay quiet after any disabled cycle
    a_r9_top_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(monitor_en) |-> !wake_pulse);

    // R10: outputs are clear while reset is held
    a_r10_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !wake_pulse && !wake_local);
endmodule

// File: tb/bus_pin_wake_detector_tb_top.sv
module bus_pin_wake_detector_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic monitor_en = 1'b1;
    logic bus_dom = 1'b0;
    logic wake_pin = 1'b1;
    logic wake_pulse, wake_local;

    int n_checks = 0;
    int n_fail = 0;
    int pulses = 0;
    int locals = 0;
    int orphans = 0;
    int back2back = 0;
    logic prev_pulse = 1'b0;

    always #2 clk = ~clk;

    bus_pin_wake_detector #(
        .DOM_MIN(4), .REC_MIN(3), .PAT_TIMEOUT(20), .PIN_FILT(5)
    ) dut_i (
        .clk(clk), .rst(rst), .monitor_en(monitor_en), .bus_dom(bus_dom),
        .wake_pin(wake_pin), .wake_pulse(wake_pulse), .wake_local(wake_local)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wake_pulse) pulses++;
            if (wake_local) locals++;
            if (wake_local && !wake_pulse) orphans++;
            if (wake_pulse && prev_pulse) back2back++;
        end
        prev_pulse = wake_pulse;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drv(input logic dom, input logic pin, input int n);
        repeat (n) @(negedge clk) begin
            bus_dom  = dom;
            wake_pin = pin;
        end
    endtask

    task automatic settle();
        drv(1'b0, wake_pin, 25);
        @(negedge clk);
        pulses = 0; locals = 0;
    endtask

    task automatic t_remote(input string req, input int d1, input int r, input int d2, input int exp);
        settle();
        drv(1'b1, wake_pin, d1);
        drv(1'b0, wake_pin, r);
        drv(1'b1, wake_pin, d2);
        drv(1'b0, wake_pin, 8);
        chk(req, pulses, exp);
        chk(req, locals, 0);
    endtask

    task automatic t_reset();
        wake_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 pulse in reset", int'(wake_pulse), 0);
        chk("R10 local in reset", int'(wake_local), 0);
        rst = 1'b0;
        drv(1'b0, 1'b1, 20);
        chk("R10 no false wake", pulses, 0);
    endtask

    task automatic t_r1_latency();
        settle();
        drv(1'b1, wake_pin, 4);
        drv(1'b0, wake_pin, 3);
        drv(1'b1, wake_pin, 4);
        @(negedge clk);
        bus_dom = 1'b0;
        chk("R1 pulse timing", int'(wake_pulse), 1);
        chk("R1 source remote", int'(wake_local), 0);
        drv(1'b0, wake_pin, 6);
        chk("R1 count", pulses, 1);
    endtask

    task automatic t_local(input string req, input logic lvl, input int hold, input int exp);
        logic orig;
        settle();
        orig = wake_pin;
        drv(1'b0, lvl, hold);
        drv(1'b0, (hold < 5) ? orig : lvl, 10);
        chk(req, pulses, exp);
        chk(req, locals, exp);
    endtask

    task automatic t_disabled();
        settle();
        monitor_en = 1'b0;
        drv(1'b1, 1'b1, 4);
        drv(1'b0, 1'b1, 3);
        drv(1'b1, 1'b0, 4);
        drv(1'b0, 1'b0, 10);
        chk("R9 disabled", pulses, 0);
        monitor_en = 1'b1;
        drv(1'b0, 1'b0, 20);
        chk("R9 re-enable", pulses, 0);
        drv(1'b0, 1'b1, 8);
        chk("R9 active again", locals, 1);
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_r1_latency();
        t_remote("R1 long first phase", 10, 3, 4, 1);
        t_remote("R2 short first dominant", 3, 3, 4, 0);
        t_remote("R3 short recessive", 4, 2, 4, 0);
        t_remote("R4 short second dominant", 4, 3, 3, 0);
        t_remote("R5 on deadline", 4, 12, 4, 1);
        t_remote("R5 past deadline", 4, 13, 4, 0);
        wake_pin = 1'b0;
        t_local("R6 rising", 1'b1, 5, 1);
        t_local("R7 falling", 1'b0, 5, 1);
        t_local("R8 short rise", 1'b1, 4, 0);
        t_disabled();
        chk("R11 orphan source", orphans, 0);
        chk("R11 single cycle", back2back, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule